// File: doc/BRIEF.md
# Sliced 32-bit Arithmetic/Logic Unit with Cascaded Magnitude Compare

This block is a purely combinational arithmetic/logic unit. It takes two 32-bit operands, a carry-in and a 3-bit function select, and returns a 32-bit result, a carry-out and two unsigned comparison flags. The datapath is split into four identical 8-bit slices. All slices see the same select code. Each slice produces one byte of the result, a carry for the slice above it, and local greater and equal flags for its own byte.

The top level chains the slice carries from the lowest byte to the highest. It merges the per-slice compare flags into word-wide flags, with the most significant byte taking priority. The compare flags are computed for every select value, so one pass through the unit can give a logic or arithmetic result and a magnitude comparison together. Slice width and slice count are parameters. The function map is fixed.

Top module: `sliced_alu`

## Requirements
- R1: Select code 3'b000 gives the result equal to operand A.
- R2: Select code 3'b001 gives the result equal to the bitwise complement of operand A.
- R3: Select code 3'b010 gives the result equal to the low 32 bits of A + B + carry-in. The carry-out port carries bit 32 of that sum.
- R4: Select code 3'b011 gives A OR B, and select code 3'b100 gives A AND B.
- R5: Select code 3'b101 gives the bitwise complement of operand B, and select code 3'b110 gives operand B.
- R6: Select code 3'b111 gives an all-zero result, whatever the operands and carry-in.
- R7: For every select code other than 3'b010, the carry-out port is 0, whatever the carry-in.
- R8: The equal flag is 1 exactly when A equals B, for every select code.
- R9: The greater flag is 1 exactly when A is greater than B as unsigned 32-bit numbers, for every select code.
- R10: During addition the carry travels through all four slices. With A all ones, B zero and carry-in 1, the result is zero and the carry-out is 1. An addition result depends on the carry-in as well as on the operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Operand B |
| cin_i | input | 1 | Carry into the lowest slice |
| fsel_i | input | 3 | Function select, shared by all slices |
| res_o | output | 32 | Function result |
| cout_o | output | 1 | Carry out of the highest slice (addition only) |
| gt_o | output | 1 | A greater than B, unsigned |
| eq_o | output | 1 | A equal to B |

## Verification
The hardest cases to reach are the ones where a decision passes through every slice. One is an addition whose carry must ripple from bit 0 to the carry-out. The other is a comparison where the upper bytes are equal and only the lowest byte decides. Random operands almost never produce either. The stimulus therefore adds directed vectors for these. It uses all-ones plus zero with carry-in set, and operand pairs that match in their upper three bytes and differ only in the lowest byte in either direction. It also uses fully equal operands under every select. It then runs random operands and random carry-in for each of the eight select codes.

// File: rtl/sliced_alu_pkg.sv
package sliced_alu_pkg;

  typedef enum logic [2:0] {
    FN_PASS_A = 3'b000,
    FN_NOT_A  = 3'b001,
    FN_ADD    = 3'b010,
    FN_OR     = 3'b011,
    FN_AND    = 3'b100,
    FN_NOT_B  = 3'b101,
    FN_PASS_B = 3'b110,
    FN_ZERO   = 3'b111
  } fn_e;

  typedef struct packed {
    logic gt;
    logic eq;
  } cmp_t;

endpackage

// File: rtl/alu_slice_arith.sv
module alu_slice_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  output logic [W-1:0] sum_o,
  output logic         co_o
);
  logic [W:0] wide;

  always_comb begin
    wide  = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, ci_i};
    sum_o = wide[W-1:0];
    co_o  = wide[W];
  end
endmodule

// File: rtl/alu_slice_cmp.sv
module alu_slice_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0]         a_i,
  input  logic [W-1:0]         b_i,
  output sliced_alu_pkg::cmp_t flg_o
);
  always_comb begin
    flg_o.gt = (a_i > b_i);
    flg_o.eq = (a_i == b_i);
  end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import sliced_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  input  fn_e          fn_i,
  output logic [W-1:0] y_o,
  output logic         co_o,
  output cmp_t         flg_o
);
  logic [W-1:0] sum;
  logic         sum_co;

  alu_slice_arith #(.W(W)) u_arith (
    .a_i  (a_i),
    .b_i  (b_i),
    .ci_i (ci_i),
    .sum_o(sum),
    .co_o (sum_co)
  );

  alu_slice_cmp #(.W(W)) u_cmp (
    .a_i  (a_i),
    .b_i  (b_i),
    .flg_o(flg_o)
  );

  always_comb begin
    co_o = 1'b0;
    unique case (fn_i)
      FN_PASS_A: y_o = a_i;
      FN_NOT_A:  y_o = ~a_i;
      FN_ADD: begin
        y_o  = sum;
        co_o = sum_co;
      end
      FN_OR:     y_o = a_i | b_i;
      FN_AND:    y_o = a_i & b_i;
      FN_NOT_B:  y_o = ~b_i;
      FN_PASS_B: y_o = b_i;
      default:   y_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_cmp_merge.sv
module alu_cmp_merge
  import sliced_alu_pkg::*;
#(
  parameter int N = 4
) (
  input  cmp_t [N-1:0] slc_i,
  output logic         gt_o,
  output logic         eq_o
);
  always_comb begin
    gt_o = 1'b0;
    eq_o = 1'b1;
    for (int i = 0; i < N; i++) begin
      gt_o = slc_i[i].gt | (slc_i[i].eq & gt_o);
      eq_o = eq_o & slc_i[i].eq;
    end
  end
endmodule

// File: rtl/sliced_alu.sv
module sliced_alu
  import sliced_alu_pkg::*;
#(
  parameter int SLICE_W = 8,
  parameter int SLICES  = 4,
  localparam int DW     = SLICE_W * SLICES
) (
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  input  logic          cin_i,
  input  logic [2:0]    fsel_i,
  output logic [DW-1:0] res_o,
  output logic          cout_o,
  output logic          gt_o,
  output logic          eq_o
);
  logic [SLICES:0]    carry;
  cmp_t [SLICES-1:0]  flg;
  fn_e                fn;

  assign fn       = fn_e'(fsel_i);
  assign carry[0] = cin_i;

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    alu_slice #(.W(SLICE_W)) u_slice (
      .a_i  (opa_i[s*SLICE_W +: SLICE_W]),
      .b_i  (opb_i[s*SLICE_W +: SLICE_W]),
      .ci_i (carry[s]),
      .fn_i (fn),
      .y_o  (res_o[s*SLICE_W +: SLICE_W]),
      .co_o (carry[s+1]),
      .flg_o(flg[s])
    );
  end

  assign cout_o = carry[SLICES];

  alu_cmp_merge #(.N(SLICES)) u_merge (
    .slc_i(flg),
    .gt_o (gt_o),
    .eq_o (eq_o)
  );
endmodule

// File: rtl/sliced_alu_chk.sv
module sliced_alu_chk #(
  parameter int DW = 32
) (
  input logic [DW-1:0] opa_i,
  input logic [DW-1:0] opb_i,
  input logic          cin_i,
  input logic [2:0]    fsel_i,
  input logic [DW-1:0] res_o,
  input logic          cout_o,
  input logic          gt_o,
  input logic          eq_o
);
  logic [DW:0] add_ref;
  assign add_ref = {1'b0, opa_i} + {1'b0, opb_i} + {{DW{1'b0}}, cin_i};

  always_comb begin
    if (fsel_i == 3'b111)
      a_r6_zero: assert (res_o == '0) else $error("R6 result not zero");
    if (fsel_i != 3'b010)
      a_r7_cout_quiet: assert (cout_o == 1'b0) else $error("R7 carry-out set");
    if (fsel_i == 3'b010)
      a_r3_add: assert ({cout_o, res_o} == add_ref) else $error("R3 sum mismatch");
    a_r8_equal: assert (eq_o == (opa_i == opb_i)) else $error("R8 equal flag");
    a_r9_greater: assert (gt_o == (opa_i > opb_i)) else $error("R9 greater flag");
    a_r9_flags_exclusive: assert (!(gt_o && eq_o)) else $error("R9 gt with eq");
  end
endmodule

bind sliced_alu sliced_alu_chk #(.DW(DW)) u_chk (
  .opa_i (opa_i),
  .opb_i (opb_i),
  .cin_i (cin_i),
  .fsel_i(fsel_i),
  .res_o (res_o),
  .cout_o(cout_o),
  .gt_o  (gt_o),
  .eq_o  (eq_o)
);

// File: tb/tb_sliced_alu.sv
`timescale 1ns/1ps
module tb_sliced_alu;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] opa, opb;
  logic          cin;
  logic [2:0]    fsel;
  logic [DW-1:0] res;
  logic          cout, gt, eq;

  always #10 clk = ~clk;

  sliced_alu dut (
    .opa_i (opa),
    .opb_i (opb),
    .cin_i (cin),
    .fsel_i(fsel),
    .res_o (res),
    .cout_o(cout),
    .gt_o  (gt),
    .eq_o  (eq)
  );

  typedef struct {
    logic [DW-1:0] res;
    logic          cout;
    logic          gt;
    logic          eq;
    logic [2:0]    fsel;
  } exp_t;

  exp_t  sb_q[$];
  string tag_q[$];
  int    n_vec  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  function automatic string res_tag(input logic [2:0] f);
    case (f)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b011, 3'b100: return "R4";
      3'b101, 3'b110: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic drive(input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input logic c, input logic [2:0] f, input string tag);
    exp_t        e;
    logic [DW:0] s;
    @(posedge clk);
    opa = a; opb = b; cin = c; fsel = f;
    s = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, c};
    e.cout = 1'b0;
    case (f)
      3'b000: e.res = a;
      3'b001: e.res = ~a;
      3'b010: begin e.res = s[DW-1:0]; e.cout = s[DW]; end
      3'b011: e.res = a | b;
      3'b100: e.res = a & b;
      3'b101: e.res = ~b;
      3'b110: e.res = b;
      default: e.res = '0;
    endcase
    e.gt   = (a > b);
    e.eq   = (a == b);
    e.fsel = f;
    sb_q.push_back(e);
    tag_q.push_back(tag == "" ? res_tag(f) : tag);
  endtask

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t  e;
      string t;
      e = sb_q.pop_front();
      t = tag_q.pop_front();
      n_vec++;
      if (res !== e.res) begin
        n_fail++;
        $display("FAIL %s result fsel=%b act=%h exp=%h", t, e.fsel, res, e.res);
      end
      if (cout !== e.cout) begin
        n_fail++;
        $display("FAIL %s carry-out fsel=%b act=%b exp=%b",
                 (e.fsel == 3'b010) ? "R3" : "R7", e.fsel, cout, e.cout);
      end
      if (eq !== e.eq) begin
        n_fail++;
        $display("FAIL R8 equal fsel=%b act=%b exp=%b", e.fsel, eq, e.eq);
      end
      if (gt !== e.gt) begin
        n_fail++;
        $display("FAIL R9 greater fsel=%b act=%b exp=%b", e.fsel, gt, e.gt);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired act=%0d exp<100000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    opa = '0; opb = '0; cin = 1'b0; fsel = 3'b000;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // idle state after reset: zero operands, pass A (R1, R8, R9)
    drive('0, '0, 1'b0, 3'b000, "R1");

    // R10: full ripple through all slices, and carry-in sensitivity
    drive('1, '0, 1'b1, 3'b010, "R10");
    drive('1, '0, 1'b0, 3'b010, "R10");
    drive(32'h00FF_FFFF, 32'h0000_0001, 1'b0, 3'b010, "R10");
    drive(32'h7FFF_FFFF, 32'h8000_0000, 1'b1, 3'b010, "R10");
    drive('1, '1, 1'b1, 3'b010, "R3");

    // R7: carry-out stays low under carry-producing operands
    for (int f = 0; f < 8; f++)
      if (f != 2) drive('1, '1, 1'b1, 3'(f), "");

    // R8/R9: decided only in the lowest byte, and equal operands
    for (int f = 0; f < 8; f++) begin
      drive(32'hABCD_EF11, 32'hABCD_EF10, 1'(f & 1), 3'(f), "");
      drive(32'hABCD_EF10, 32'hABCD_EF11, 1'(f & 1), 3'(f), "");
      drive(32'h1234_5678, 32'h1234_5678, 1'(f & 1), 3'(f), "");
      drive(32'h8000_0000, 32'h7FFF_FFFF, 1'(f & 1), 3'(f), "");
    end

    // random operands for every select (R1..R9)
    for (int f = 0; f < 8; f++)
      for (int k = 0; k < 200; k++)
        drive($urandom, $urandom, 1'($urandom), 3'(f), "");

    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule